// File: doc/BRIEF.md
# Bit-Error Counter Snapshot Controller

This block keeps the two running counts of a bit-error-rate tester: how many received bits were valid, and how many of those were in error. On request it freezes both counts into holding registers that the host can read, and it restarts the live counters in the same clock. The host reads each frozen count as two register halves, a lower and an upper word.

A mode bit selects where the snapshot request comes from. In local mode, a rising edge of a control bit written by software starts the snapshot. In shared mode, a rising edge of a global or port update strobe starts it, and the local bit does nothing. The strobe is passed through a two-flop synchroniser before its edge is detected. Switching the mode bit while the newly chosen source is already high counts as an edge. A sticky completion flag rises one clock after the snapshot and stays set until the local control bit falls. A datapath reset or a power-down input clears every register in the block.

Top module: `ber_snapshot_ctrl`

## Requirements
- R1: While `dp_reset` or `power_down` is high at a clock edge, every register of the block clears: the control bits, the completion flag, the live counters and both holding registers. After reset, all readable addresses return 0.
- R2: When the mode bit (control bit 0) is 0, a 0-to-1 change of the local request bit (control bit 1) starts a snapshot. The control register is written at address 0.
- R3: A local request bit held at 1 gives exactly one snapshot. A further snapshot needs the bit to go to 0 and then back to 1.
- R4: When the mode bit is 1, a rising edge of `glb_update` starts a snapshot once it has passed the two-flop synchroniser, and changes of the local request bit start none.
- R5: A snapshot copies the live bit count and error count into the holding registers and restarts both counters. A valid bit that arrives in the snapshot cycle is counted as 1 in the new interval.
- R6: The completion flag (status address 1, bit 0) reads 1 from the clock after a snapshot. It stays set until the local request bit falls. When a snapshot and a fall happen together, the set wins.
- R7: Changing the mode bit while the newly selected source is high starts a snapshot.
- R8: The live counters are `CNT_W` bits wide and stay at all-ones instead of wrapping.
- R9: The bit count is read at address 2 (lower half) and address 3 (upper half). The error count is read at address 4 (lower) and address 5 (upper). Addresses 6 and 7 read 0.
- R10: An error is counted only when `bit_valid` and `bit_error` are both high. The error count never exceeds the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_reset | input | 1 | Synchronous datapath reset, clears all registers |
| power_down | input | 1 | Synchronous power-down, clears all registers |
| bit_valid | input | 1 | A received bit is present this cycle |
| bit_error | input | 1 | The present bit is in error |
| glb_update | input | 1 | Global/port snapshot strobe (asynchronous) |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W/2 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W/2 | Register read data (combinational) |
| snap_done | output | 1 | Sticky snapshot completion flag |

## Verification
The assertions assume that `bit_error` matters only together with `bit_valid`. They also assume that `dp_reset` and `power_down` are sampled synchronously and that `wr_addr` is stable while `wr_en` is high. The stimulus changes every input at the falling clock edge, so each rising edge sees settled values. The asynchronous strobe is held for several cycles, so the synchroniser always captures it. The bench uses an 8-bit counter width so that saturation can be reached in a few hundred cycles.

// File: rtl/ber_snap_pkg.sv
`timescale 1ns/1ps
package ber_snap_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_BITS_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_BITS_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_ERRS_LO = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_ERRS_HI = 3'd5;
  localparam int CTRL_MODE_BIT  = 0;
  localparam int CTRL_LOCAL_BIT = 1;
endpackage

// File: rtl/ber_trig_sel.sv
`timescale 1ns/1ps
module ber_trig_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic src_glb,
  input  logic local_req,
  input  logic glb_strobe,
  output logic fire
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic glb_lvl;
  logic sel_lvl;
  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sync_q <= '0;
    else if (clr) sync_q <= '0;
    else          sync_q <= {sync_q[SYNC_STAGES-2:0], glb_strobe};
  end

  assign glb_lvl = sync_q[SYNC_STAGES-1];
  assign sel_lvl = src_glb ? glb_lvl : local_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sel_q <= 1'b0;
    else if (clr) sel_q <= 1'b0;
    else          sel_q <= sel_lvl;
  end

  assign fire = sel_lvl & ~sel_q & ~clr;

  // R3: a held level never fires twice in a row
  a_r3_one_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R4: in shared mode the local bit cannot start a snapshot
  a_r4_local_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (src_glb && $past(src_glb) && $stable(glb_lvl)) |-> !fire);
endmodule

// File: rtl/ber_sat_counter.sv
`timescale 1ns/1ps
module ber_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         restart,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = '1;

  function automatic logic [W-1:0] sat_step(input logic [W-1:0] v, input logic up);
    if (up && v != MAXV) return v + 1'b1;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (clr)     q <= '0;
    else if (restart) q <= {{(W-1){1'b0}}, inc};
    else              q <= sat_step(q, inc);
  end

  // R8: a saturated count stays saturated until restarted
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !restart && q == MAXV) |=> q == MAXV);
  // R5: restart loads the bit of the snapshot cycle
  a_r5_restart_value: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && restart) |=> q == {{(W-1){1'b0}}, $past(inc)});
endmodule

// File: rtl/ber_snapshot_ctrl.sv
`timescale 1ns/1ps
module ber_snapshot_ctrl
  import ber_snap_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dp_reset,
  input  logic                  power_down,
  input  logic                  bit_valid,
  input  logic                  bit_error,
  input  logic                  glb_update,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [CNT_W/2-1:0]    wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [CNT_W/2-1:0]    rd_data,
  output logic                  snap_done
);
  localparam int HALF_W = CNT_W / 2;
  localparam int NCNT   = 2;

  logic clr;
  logic mode_glb, local_req, local_prev, local_fall;
  logic fire;
  logic [NCNT-1:0]  cnt_inc;
  logic [CNT_W-1:0] cnt_q [NCNT];
  logic [CNT_W-1:0] hold_bits, hold_errs;
  logic unused_wr_bits;

  assign clr = dp_reset | power_down;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_glb  <= 1'b0;
      local_req <= 1'b0;
    end else if (clr) begin
      mode_glb  <= 1'b0;
      local_req <= 1'b0;
    end else if (wr_en && wr_addr == ADR_CTRL) begin
      mode_glb  <= wr_data[CTRL_MODE_BIT];
      local_req <= wr_data[CTRL_LOCAL_BIT];
    end
  end

  ber_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n), .clr(clr), .src_glb(mode_glb),
    .local_req(local_req), .glb_strobe(glb_update), .fire(fire));

  assign cnt_inc[0] = bit_valid;
  assign cnt_inc[1] = bit_valid & bit_error;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    ber_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .restart(fire),
      .inc(cnt_inc[g]), .q(cnt_q[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_bits <= '0;
      hold_errs <= '0;
    end else if (clr) begin
      hold_bits <= '0;
      hold_errs <= '0;
    end else if (fire) begin
      hold_bits <= cnt_q[0];
      hold_errs <= cnt_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   local_prev <= 1'b0;
    else if (clr) local_prev <= 1'b0;
    else          local_prev <= local_req;
  end
  assign local_fall = local_prev & ~local_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          snap_done <= 1'b0;
    else if (clr)        snap_done <= 1'b0;
    else if (fire)       snap_done <= 1'b1;
    else if (local_fall) snap_done <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL:    rd_data = {{(HALF_W-2){1'b0}}, local_req, mode_glb};
      ADR_STAT:    rd_data = {{(HALF_W-1){1'b0}}, snap_done};
      ADR_BITS_LO: rd_data = hold_bits[HALF_W-1:0];
      ADR_BITS_HI: rd_data = hold_bits[CNT_W-1:HALF_W];
      ADR_ERRS_LO: rd_data = hold_errs[HALF_W-1:0];
      ADR_ERRS_HI: rd_data = hold_errs[CNT_W-1:HALF_W];
      default:     rd_data = '0;
    endcase
  end

  // R1: a clear empties every register
  a_r1_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hold_bits == '0 && hold_errs == '0 && !snap_done &&
             !mode_glb && !local_req && cnt_q[0] == '0));
  // R2: a snapshot captures the live counts
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (hold_bits == $past(cnt_q[0]) && hold_errs == $past(cnt_q[1])));
  // R6: completion flag follows each snapshot
  a_r6_done_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> snap_done);
  // R10: errors never outnumber bits
  a_r10_err_le_bits: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[1] <= cnt_q[0]);
endmodule

// File: tb/ber_snapshot_ctrl_test.sv
`timescale 1ns/1ps
module ber_snapshot_ctrl_test;
  localparam int CW = 8;
  localparam int HW = CW / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp_reset = 0, power_down = 0, bit_valid = 0, bit_error = 0, glb_update = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [HW-1:0] wr_data = '0;
  logic [HW-1:0] rd_data;
  logic snap_done;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ber_snapshot_ctrl #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .dp_reset(dp_reset), .power_down(power_down),
    .bit_valid(bit_valid), .bit_error(bit_error), .glb_update(glb_update),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .snap_done(snap_done));

  typedef struct packed {
    logic       glb;
    logic [8:0] nbits;
    logic [8:0] nerrs;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{glb: 1'b0, nbits: 9'd10, nerrs: 9'd3},
    '{glb: 1'b1, nbits: 9'd25, nerrs: 9'd0},
    '{glb: 1'b0, nbits: 9'd40, nerrs: 9'd40},
    '{glb: 1'b1, nbits: 9'd7,  nerrs: 9'd2}
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [HW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  task automatic rd_word(input logic [2:0] lo, output int v);
    int l, h;
    rd(lo, l); rd(lo + 3'd1, h);
    v = h * (1 << HW) + l;
  endtask

  task automatic send_bits(input int n, input int nerr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = 1; bit_error = (i < nerr);
    end
    @(negedge clk);
    bit_valid = 0; bit_error = 0;
  endtask

  task automatic glb_pulse();
    @(negedge clk); glb_update = 1;
    repeat (4) @(negedge clk);
    glb_update = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_hold(input string tag, input int eb, input int ee);
    int v;
    rd_word(3'd2, v); chk({tag, " bits"}, v, eb);
    rd_word(3'd4, v); chk({tag, " errs"}, v, ee);
  endtask

  function automatic int sat(input int v);
    return (v > (1 << CW) - 1) ? (1 << CW) - 1 : v;
  endfunction

  initial begin
    #1ms;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 / R9: reset state, every address reads 0
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk($sformatf("R1 R9 reset addr %0d", a), v, 0);
    end

    // R2 R4 R5: vector table
    for (int k = 0; k < 4; k++) begin
      wr(3'd0, {2'b00, 1'b0, VECS[k].glb});
      repeat (2) @(negedge clk);
      send_bits(int'(VECS[k].nbits), int'(VECS[k].nerrs));
      if (VECS[k].glb) glb_pulse();
      else begin
        wr(3'd0, 4'b0010);
        repeat (2) @(negedge clk);
      end
      check_hold($sformatf("R2 R4 R5 vec %0d", k),
                 sat(int'(VECS[k].nbits)), sat(int'(VECS[k].nerrs)));
      rd(3'd1, v); chk($sformatf("R6 done vec %0d", k), v, 1);
    end

    // R6: flag sticky in shared mode with local bit low
    repeat (5) @(negedge clk);
    rd(3'd1, v); chk("R6 sticky", v, 1);

    // R4: local edge ignored in shared mode
    send_bits(6, 1);
    wr(3'd0, 4'b0011);
    repeat (3) @(negedge clk);
    check_hold("R4 local ignored", 7, 2);
    wr(3'd0, 4'b0001);
    @(negedge clk);
    rd(3'd1, v); chk("R6 clear on local fall", v, 0);
    glb_pulse();
    check_hold("R4 strobe", 6, 1);
    rd(3'd1, v); chk("R6 set by strobe", v, 1);

    // R5 R3: bit in snapshot cycle, held request
    wr(3'd0, 4'b0000);
    send_bits(3, 0);
    wr(3'd0, 4'b0010);
    bit_valid = 1; bit_error = 1;
    @(negedge clk);
    bit_valid = 0; bit_error = 0;
    @(negedge clk);
    check_hold("R5 capture before same-cycle bit", 3, 0);
    send_bits(4, 0);
    repeat (3) @(negedge clk);
    check_hold("R3 held request", 3, 0);
    wr(3'd0, 4'b0000);
    @(negedge clk);
    rd(3'd1, v); chk("R6 clear", v, 0);
    wr(3'd0, 4'b0010);
    repeat (2) @(negedge clk);
    check_hold("R5 same-cycle bit in new interval", 5, 1);

    // R7: mode change while strobe already high
    wr(3'd0, 4'b0000);
    glb_update = 1;
    repeat (4) @(negedge clk);
    send_bits(2, 0);
    rd(3'd1, v); chk("R7 no snapshot yet", v, 0);
    wr(3'd0, 4'b0001);
    repeat (2) @(negedge clk);
    check_hold("R7 mode switch", 2, 0);
    glb_update = 0;
    repeat (3) @(negedge clk);

    // R10: error without valid is not counted
    wr(3'd0, 4'b0000);
    @(negedge clk); bit_error = 1;
    repeat (5) @(negedge clk);
    bit_error = 0;
    send_bits(3, 1);
    wr(3'd0, 4'b0010);
    repeat (2) @(negedge clk);
    check_hold("R10 qualified errors", 3, 1);

    // R8: saturation
    wr(3'd0, 4'b0000);
    send_bits(300, 300);
    wr(3'd0, 4'b0010);
    repeat (2) @(negedge clk);
    check_hold("R8 saturate", 255, 255);

    // R1: datapath reset
    @(negedge clk); dp_reset = 1;
    @(negedge clk); dp_reset = 0;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk($sformatf("R1 dp_reset addr %0d", a), v, 0);
    end

    // R1: power-down, also restarts the live counters
    send_bits(9, 4);
    @(negedge clk); power_down = 1;
    @(negedge clk); power_down = 0;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk($sformatf("R1 power_down addr %0d", a), v, 0);
    end
    send_bits(2, 0);
    wr(3'd0, 4'b0010);
    repeat (2) @(negedge clk);
    check_hold("R1 counters cleared by power_down", 2, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule